// File: doc/BRIEF.md
# Layer Enable Delay Controller

This block sits between the display control register and the rendering pipeline. It turns the requested visibility of four background layers and the sprite layer, and the requested forced-blank state, into the effective controls the pipeline actually obeys. The timing is deliberately asymmetric. Anything that hides content or lifts the blank takes effect at once. Anything that reveals a layer or blanks the panel during the visible part of the frame waits until three more visible lines have started.

Requests made while the raster is in vertical blank do not wait out that delay. They take effect at the first visible line start. The block is told where the raster is by a one-cycle line-start strobe and a visibility level. The level is valid together with the strobe and describes the line that is starting.

While forced blank is effective, the panel is driven white and the processor is granted access to the video memories. The raster counters are outside this block and keep running regardless.

Top module: `layer_enable_delay`

## Requirements
- R1: With the forced-blank request held high and all layer requests low, during reset and right after it, every effective layer enable is 0 and both the effective forced blank and the memory grant are 1.
- R2: Dropping a layer request (bit 0..3 of `layer_req_i` = backgrounds 0..3, bit 4 = sprites) clears that layer's effective enable in the same cycle.
- R3: A layer request raised during a visible line takes effect in the cycle after the third visible line start that follows. After two such starts it is still off.
- R4: If a pending request drops for even one cycle and rises again, the three-line wait restarts from zero.
- R5: A request that is pending at any cycle while the raster is in a non-visible line takes effect in the cycle after the next visible line start. Line starts of non-visible lines do not advance the three-line count.
- R6: Dropping the forced-blank request clears the effective forced blank and the memory grant in the same cycle.
- R7: Raising the forced-blank request during a visible line drives the effective forced blank and the grant high only after the third visible line start that follows. Between line starts they do not change while the request is steady.
- R8: Each of the six channels (five layers and forced blank) keeps its own timing, unaffected by the requests of the others.
- R9: Once a channel is effective, later line starts leave it on for as long as its request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| layer_req_i | input | NUM_LAYERS (5) | Requested layer enables from the control register |
| fblank_req_i | input | 1 | Requested forced blank from the control register |
| line_start_i | input | 1 | One-cycle pulse at the start of each raster line |
| line_visible_i | input | 1 | 1 when the current or starting line is a visible line |
| layer_eff_o | output | NUM_LAYERS (5) | Effective layer enables for the pipeline |
| fblank_eff_o | output | 1 | Effective forced blank; the panel shows white |
| vram_grant_o | output | 1 | Processor access to video, palette and sprite memories granted |

## Verification
A channel whose line counter is off by one shows up as an enable that rises one line early or one line late, visible at the ports within one line period of the expected start. A lost blank-time flag delays a layer by up to three visible lines after vertical blank. A stale flag makes a layer appear at the first line start while it should still be counting. A counter that fails to clear on a short drop of the request turns the layer on too early after the re-raise. Every such slip appears as a wrong effective enable on the very cycle the reference model expects the change.

// File: rtl/lde_pkg.sv
package lde_pkg;

  // Index of each layer inside the request and effective vectors
  typedef enum logic [2:0] {
    LYR_BG0 = 3'd0,
    LYR_BG1 = 3'd1,
    LYR_BG2 = 3'd2,
    LYR_BG3 = 3'd3,
    LYR_SPR = 3'd4
  } lde_layer_e;

  localparam int unsigned LDE_LAYERS_DEF = 5;
  localparam int unsigned LDE_DELAY_DEF  = 3;

  // Per-channel control flags
  typedef struct packed {
    logic on;    // channel effective (before gating by request)
    logic fast;  // blank time seen while pending
  } lde_flags_t;

endpackage

// File: rtl/lde_rst_sync.sv
module lde_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/lde_chan.sv
module lde_chan
  import lde_pkg::*;
#(
  parameter int unsigned LINES  = 3,
  parameter bit          RST_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic line_i,
  input  logic vis_i,
  output logic eff_o
);

  localparam int unsigned CW = $clog2(LINES + 1);
  localparam logic [CW-1:0] LAST = CW'(LINES - 1);

  lde_flags_t      flg_q, flg_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            ce;

  // next state
  always_comb begin
    flg_d = flg_q;
    cnt_d = cnt_q;
    if (!req_i) begin
      flg_d = '0;
      cnt_d = '0;
    end else if (!flg_q.on) begin
      if (!vis_i) begin
        flg_d.fast = 1'b1;
      end else if (line_i) begin
        if (flg_q.fast || (cnt_q == LAST)) begin
          flg_d.on   = 1'b1;
          flg_d.fast = 1'b0;
          cnt_d      = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  // state only moves while idle-off or pending
  assign ce = !req_i || !flg_q.on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q.on   <= RST_ON;
      flg_q.fast <= 1'b0;
      cnt_q      <= '0;
    end else if (ce) begin
      flg_q <= flg_d;
      cnt_q <= cnt_d;
    end
  end

  // switching off acts in the same cycle
  assign eff_o = req_i && flg_q.on;

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LINES)); // R3

  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (cnt_q == '0 && !flg_q.fast)); // R4

  AST_RISE_AT_VISIBLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && $past(req_i) && eff_o && !$past(eff_o)) |-> $past(line_i && vis_i)); // R5

  AST_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q.on && req_i) |=> flg_q.on); // R9

endmodule

// File: rtl/lde_bank.sv
module lde_bank
  import lde_pkg::*;
#(
  parameter int unsigned N     = LDE_LAYERS_DEF,
  parameter int unsigned LINES = LDE_DELAY_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         line_i,
  input  logic         vis_i,
  output logic [N-1:0] eff_o
);

  for (genvar g = 0; g < N; g++) begin : g_ch
    lde_chan #(
      .LINES  (LINES),
      .RST_ON (1'b0)
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i[g]),
      .line_i (line_i),
      .vis_i  (vis_i),
      .eff_o  (eff_o[g])
    );
  end

endmodule

// File: rtl/layer_enable_delay.sv
module layer_enable_delay
  import lde_pkg::*;
#(
  parameter int unsigned NUM_LAYERS  = LDE_LAYERS_DEF,
  parameter int unsigned DELAY_LINES = LDE_DELAY_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LAYERS-1:0] layer_req_i,
  input  logic                  fblank_req_i,
  input  logic                  line_start_i,
  input  logic                  line_visible_i,
  output logic [NUM_LAYERS-1:0] layer_eff_o,
  output logic                  fblank_eff_o,
  output logic                  vram_grant_o
);

  logic srst_n;

  lde_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  lde_bank #(
    .N     (NUM_LAYERS),
    .LINES (DELAY_LINES)
  ) u_layers (
    .clk    (clk),
    .rst_n  (srst_n),
    .req_i  (layer_req_i),
    .line_i (line_start_i),
    .vis_i  (line_visible_i),
    .eff_o  (layer_eff_o)
  );

  // forced blank: asserting is the delayed direction, like showing a layer
  lde_chan #(
    .LINES  (DELAY_LINES),
    .RST_ON (1'b1)
  ) u_blank (
    .clk    (clk),
    .rst_n  (srst_n),
    .req_i  (fblank_req_i),
    .line_i (line_start_i),
    .vis_i  (line_visible_i),
    .eff_o  (fblank_eff_o)
  );

  assign vram_grant_o = fblank_eff_o;

  AST_BLANK_STEADY_MIDLINE: assert property (@(posedge clk) disable iff (!srst_n)
    (fblank_req_i && $past(fblank_req_i) && !$past(line_start_i))
      |-> (fblank_eff_o == $past(fblank_eff_o))); // R7

endmodule

// File: tb/sim_layer_enable_delay.sv
module sim_layer_enable_delay;

  localparam int NL = 5;
  localparam int DL = 3;
  localparam int LINE_CYC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] lreq;
  logic          breq, lstr, lvis;
  logic [NL-1:0] leff;
  logic          beff, gnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  layer_enable_delay #(.NUM_LAYERS(NL), .DELAY_LINES(DL)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .layer_req_i    (lreq),
    .fblank_req_i   (breq),
    .line_start_i   (lstr),
    .line_visible_i (lvis),
    .layer_eff_o    (leff),
    .fblank_eff_o   (beff),
    .vram_grant_o   (gnt)
  );

  // behavioural reference: channel 0..NL-1 layers, channel NL forced blank
  int m_on   [NL+1];
  int m_cnt  [NL+1];
  int m_pend [NL+1];
  int hi_edges = 0;

  function automatic int req_of(int ch);
    return (ch < NL) ? int'(lreq[ch]) : int'(breq);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) hi_edges = 0;
    else        hi_edges = hi_edges + 1;
    for (int ch = 0; ch <= NL; ch++) begin
      if (hi_edges < 3) begin
        m_on[ch] = (ch == NL) ? 1 : 0; m_cnt[ch] = 0; m_pend[ch] = 0;
      end else if (req_of(ch) == 0) begin
        m_on[ch] = 0; m_cnt[ch] = 0; m_pend[ch] = 0;
      end else if (m_on[ch] == 0) begin
        if (!lvis) m_pend[ch] = 1;
        else if (lstr) begin
          if (m_pend[ch] != 0 || m_cnt[ch] + 1 >= DL) begin
            m_on[ch] = 1; m_cnt[ch] = 0; m_pend[ch] = 0;
          end else m_cnt[ch] = m_cnt[ch] + 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) begin
    if (!done) begin
      for (int ch = 0; ch < NL; ch++)
        chk("R8 model layer", int'(leff[ch]), (req_of(ch) != 0 && m_on[ch] != 0) ? 1 : 0);
      chk("R8 model blank", int'(beff), (breq && m_on[NL] != 0) ? 1 : 0);
      chk("R8 model grant", int'(gnt), (breq && m_on[NL] != 0) ? 1 : 0);
    end
  end

  task automatic drive_wait();
    @(posedge clk); #2;
  endtask

  task automatic run_line(input logic vis);
    drive_wait();
    lstr = 1'b1; lvis = vis;
    drive_wait();
    lstr = 1'b0;
    repeat (LINE_CYC - 2) drive_wait();
  endtask

  initial begin
    #(20 * 20000);
    chk("watchdog", 1, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lreq = '0; breq = 1'b1; lstr = 1'b0; lvis = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 layers", int'(leff), 0);
    chk("R1 blank", int'(beff), 1);
    chk("R1 grant", int'(gnt), 1);
    drive_wait(); rst_n = 1'b1;
    repeat (5) drive_wait();
    @(negedge clk);
    chk("R1 blank after", int'(beff), 1);
    chk("R1 layers after", int'(leff), 0);

    // R6: release forced blank
    drive_wait(); breq = 1'b0;
    @(negedge clk);
    chk("R6 blank", int'(beff), 0);
    chk("R6 grant", int'(gnt), 0);

    // R3: layer 0 on during visible line
    run_line(1'b1);
    drive_wait(); lreq[0] = 1'b1;
    repeat (2) drive_wait();
    run_line(1'b1); run_line(1'b1);
    @(negedge clk); chk("R3 two lines", int'(leff[0]), 0);
    run_line(1'b1);
    @(negedge clk); chk("R3 three lines", int'(leff[0]), 1);

    // R9: stays on across later line starts
    run_line(1'b1); run_line(1'b0); run_line(1'b1);
    @(negedge clk); chk("R9 held", int'(leff[0]), 1);

    // R2: off at once
    drive_wait(); lreq[0] = 1'b0;
    @(negedge clk); chk("R2 off", int'(leff[0]), 0);

    // R4: restart after a one-cycle drop
    drive_wait(); lreq[1] = 1'b1;
    run_line(1'b1);
    drive_wait(); lreq[1] = 1'b0;
    drive_wait(); lreq[1] = 1'b1;
    run_line(1'b1); run_line(1'b1);
    @(negedge clk); chk("R4 restarted", int'(leff[1]), 0);
    run_line(1'b1);
    @(negedge clk); chk("R4 done", int'(leff[1]), 1);

    // R7: forced blank asserted during display
    drive_wait(); breq = 1'b1;
    @(negedge clk); chk("R7 not yet", int'(beff), 0);
    run_line(1'b1); run_line(1'b1);
    @(negedge clk); chk("R7 two lines", int'(gnt), 0);
    run_line(1'b1);
    @(negedge clk); chk("R7 blank", int'(beff), 1);
    chk("R7 grant", int'(gnt), 1);
    drive_wait(); breq = 1'b0;
    @(negedge clk); chk("R6 release again", int'(gnt), 0);

    // R5: request during vertical blank
    run_line(1'b0);
    drive_wait(); lreq[2] = 1'b1;
    run_line(1'b0); run_line(1'b0); run_line(1'b0);
    @(negedge clk); chk("R5 blank lines", int'(leff[2]), 0);
    run_line(1'b1);
    @(negedge clk); chk("R5 first visible", int'(leff[2]), 1);

    // R5: request from display spanning into blank
    drive_wait(); lreq[0] = 1'b1;
    run_line(1'b1); run_line(1'b0);
    @(negedge clk); chk("R5 span pending", int'(leff[0]), 0);
    run_line(1'b1);
    @(negedge clk); chk("R5 span on", int'(leff[0]), 1);

    // R8: independent channels
    drive_wait(); lreq[3] = 1'b1;
    run_line(1'b1);
    drive_wait(); lreq[4] = 1'b1;
    run_line(1'b1); run_line(1'b1);
    @(negedge clk);
    chk("R8 layer3 on", int'(leff[3]), 1);
    chk("R8 layer4 waiting", int'(leff[4]), 0);
    drive_wait(); lreq[3] = 1'b0;
    run_line(1'b1);
    @(negedge clk);
    chk("R8 layer3 off", int'(leff[3]), 0);
    chk("R8 layer4 on", int'(leff[4]), 1);
    chk("R8 others", int'(leff[2:0]), 7);

    repeat (3) drive_wait();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule